// File: doc/BRIEF.md
# Sleep Mode Power Controller

This controller sits between the CPU core and the clock tree of a small microcontroller. It puts the device into a low-power state when software asks for it. A sleep instruction pulse, taken while the sleep-enable input is high, moves the controller into one of three depths: Idle, Standby or Power-Down. The depth is chosen by a 2-bit mode code. From that point on, the controller drives one clock-enable bit per clock domain. Each peripheral domain supplies a run-in-standby bit that decides whether it keeps its clock in Standby.

While asleep, the raw interrupt requests of the peripherals pass through a wake mask. The mask depends on the current depth, on the run-in-standby bits and, for the configurable-logic source, on whether its lookup path is asynchronous. When an unmasked request arrives, the controller does three things in that same cycle: it turns every clock on, gives the CPU a one-cycle wake pulse, and then returns to the active state on the next edge. The analog behaviour of the oscillators and any wake-up delay timing are handled elsewhere.

Top module: `sleep_power_ctrl`

## Requirements
- R1: After reset, `sleep_state` is 00 (active), every bit of `clk_en` is 1 and `wake_pulse` is 0. While active, all clocks stay on and `wake_pulse` stays 0.
- R2: A `sleep_pulse` with `sleep_en`=1 and `sleep_mode` of 00 (Idle), 01 (Standby) or 10 (Power-Down) changes `sleep_state` on the next edge to 01, 10 or 11 respectively. If `sleep_en`=0 or `sleep_mode`=11, the pulse leaves the controller active.
- R3: If a request that the requested depth would accept as a wake source is high during the `sleep_pulse` cycle, sleep entry is refused and the state stays 00.
- R4: In Idle, `clk_en` is all ones except the CPU bit (bit 0).
- R5: In Standby, the CPU bit is 0. The bits for PER (1), RTC (2), CCL (5) and TMR (6) equal the matching `run_stby` bits, and WDT (3) and BOD (4) are 1.
- R6: In Power-Down, only RTC (2), WDT (3) and BOD (4) are enabled, whatever the `run_stby` bits are.
- R7: WDT (3) and BOD (4) are enabled in every state. `run_stby` bits 0, 3 and 4 have no effect.
- R8: The pin (irq bit 0), address-match (1) and voltage-monitor (2) requests wake the device from every depth.
- R9: The start-of-frame request (bit 6) wakes the device only from Standby.
- R10: The ADC (7) and comparator (8) requests, gated by `run_stby`[1], and the timer request (9), gated by `run_stby`[6], wake the device from Idle always, from Standby only when their bit is set, and never from Power-Down.
- R11: The configurable-logic request (bit 3) wakes the device from Idle. It wakes the device from Standby when `run_stby`[5]=1, and from Power-Down only when `ccl_filt`=0 and `ccl_edge`=0.
- R12: The RTC counter request (bit 4) wakes the device from Idle, and from Standby when `run_stby`[2]=1. The periodic request (bit 5) does the same and also wakes the device from Power-Down.
- R13: Any other request (bit 10) wakes the device only from Idle.
- R14: An accepted wake sets every `clk_en` bit to 1 and `wake_pulse` to 1 in the same cycle. On the next edge the state is 00 and `wake_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_en | input | 1 | Sleep permitted |
| sleep_mode | input | 2 | Requested depth: 00 Idle, 01 Standby, 10 Power-Down, 11 reserved |
| sleep_pulse | input | 1 | One-cycle sleep instruction strobe |
| run_stby | input | 7 | Per-domain run-in-standby bits (domain order as in `clk_en`) |
| ccl_filt | input | 2 | Configurable-logic filter select |
| ccl_edge | input | 1 | Configurable-logic edge detect enable |
| irq | input | 11 | Raw peripheral interrupt requests |
| clk_en | output | 7 | Domain clock enables: CPU, PER, RTC, WDT, BOD, CCL, TMR (bits 0..6) |
| wake_pulse | output | 1 | One-cycle wake strobe to the CPU |
| sleep_state | output | 2 | 00 active, 01 Idle, 10 Standby, 11 Power-Down |

## Verification
The bench sweeps every depth against every combination of the meaningful run-in-standby bits and every single wake source, and it also sweeps all eight configurable-logic path settings. This means a mask that swaps the periodic and counter RTC sources, or that lets start-of-frame through in Idle, shows up as a wake on the wrong vector or a missing one. Standby clock gating that ignores an opt-in bit, or gating that enables PER in Power-Down, shows up as a wrong `clk_en` value while asleep. Entry is also tried with an acceptable request already high, with the reserved code and with sleep disabled. A controller that sleeps anyway in any of these cases leaves `sleep_state` nonzero. Wake timing is checked both in the wake cycle and one cycle later, so a registered wake pulse or a wake that takes an extra cycle is caught.

// File: rtl/slp_pkg.sv
// Shared constants, state type and per-mode policy functions for the sleep
// controller. Assumes a fixed list of clock domains and wake source classes.
package slp_pkg;
    localparam int NDOM   = 7;
    localparam int NSRC   = 11;
    localparam int MODE_W = 2;
    localparam int FILT_W = 2;

    // Clock domain bit positions
    localparam int D_CPU = 0;
    localparam int D_PER = 1;
    localparam int D_RTC = 2;
    localparam int D_WDT = 3;
    localparam int D_BOD = 4;
    localparam int D_CCL = 5;
    localparam int D_TMR = 6;

    // Wake source bit positions
    localparam int S_PIN = 0;
    localparam int S_TWI = 1;
    localparam int S_VLM = 2;
    localparam int S_CCL = 3;
    localparam int S_RTC = 4;
    localparam int S_PIT = 5;
    localparam int S_SOF = 6;
    localparam int S_ADC = 7;
    localparam int S_AC  = 8;
    localparam int S_TMR = 9;
    localparam int S_OTH = 10;

    typedef enum logic [1:0] {
        ST_ACT  = 2'b00,
        ST_IDLE = 2'b01,
        ST_STBY = 2'b10,
        ST_PDN  = 2'b11
    } pstate_t;

    localparam logic [MODE_W-1:0] MODE_RSVD = 2'b11;

    // Whether domain d keeps its clock in state st
    function automatic logic dom_on(int d, pstate_t st, logic [NDOM-1:0] rsb);
        logic on;
        on = 1'b1;
        if (d == D_WDT || d == D_BOD) begin
            on = 1'b1;
        end else begin
            case (st)
                ST_ACT:  on = 1'b1;
                ST_IDLE: on = (d != D_CPU);
                ST_STBY: on = (d == D_CPU) ? 1'b0 : rsb[d];
                ST_PDN:  on = (d == D_RTC);
                default: on = 1'b1;
            endcase
        end
        return on;
    endfunction

    // Whether source s may wake the device from state st
    function automatic logic src_ok(int s, pstate_t st, logic [NDOM-1:0] rsb,
                                    logic ccl_async);
        logic ok;
        ok = 1'b0;
        case (st)
            ST_ACT, ST_IDLE: ok = (s != S_SOF);
            ST_STBY: begin
                case (s)
                    S_PIN, S_TWI, S_VLM, S_SOF: ok = 1'b1;
                    S_CCL:          ok = rsb[D_CCL];
                    S_RTC, S_PIT:   ok = rsb[D_RTC];
                    S_ADC, S_AC:    ok = rsb[D_PER];
                    S_TMR:          ok = rsb[D_TMR];
                    default:        ok = 1'b0;
                endcase
            end
            ST_PDN: begin
                case (s)
                    S_PIN, S_TWI, S_VLM, S_PIT: ok = 1'b1;
                    S_CCL:   ok = ccl_async;
                    default: ok = 1'b0;
                endcase
            end
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/slp_wake_mask.sv
// Builds the per-source wake permission vector for one state.
// Assumes the caller supplies the state to evaluate; purely combinational.
module slp_wake_mask
    import slp_pkg::*;
(
    input  pstate_t              st,
    input  logic [NDOM-1:0]      rsb,
    input  logic                 ccl_async,
    output logic [NSRC-1:0]      allow
);
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // One permission bit per wake source
        always_comb allow[s] = src_ok(s, st, rsb, ccl_async);
    end
endmodule

// File: rtl/slp_clk_dec.sv
// Decodes the power state into per-domain clock enables, with a wake
// override forcing every domain on. Combinational; assumes wake is already
// qualified by the mask.
module slp_clk_dec
    import slp_pkg::*;
(
    input  pstate_t              st,
    input  logic [NDOM-1:0]      rsb,
    input  logic                 wake,
    output logic [NDOM-1:0]      clk_en
);
    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        // Enable for one domain: on during wake, otherwise by policy
        always_comb clk_en[d] = wake | dom_on(d, st, rsb);
    end
endmodule

// File: rtl/slp_seq.sv
// Holds the power state. Enters the target depth on an accepted request and
// returns to active on a wake. Assumes enter is only raised while active.
module slp_seq
    import slp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enter,
    input  pstate_t target,
    input  logic    wake,
    output pstate_t st
);
    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_ACT;
        end else if (wake) begin
            st <= ST_ACT;
        end else if (enter) begin
            st <= target;
        end
    end
endmodule

// File: rtl/sleep_power_ctrl.sv
// Sleep mode power controller top. Accepts sleep requests and gates the
// domain clocks per depth and run-in-standby bits. It also masks the
// interrupt requests to find wake events. Assumes irq and run_stby are
// synchronous to clk.
module sleep_power_ctrl
    import slp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_en,
    input  logic [MODE_W-1:0]    sleep_mode,
    input  logic                 sleep_pulse,
    input  logic [NDOM-1:0]      run_stby,
    input  logic [FILT_W-1:0]    ccl_filt,
    input  logic                 ccl_edge,
    input  logic [NSRC-1:0]      irq,
    output logic [NDOM-1:0]      clk_en,
    output logic                 wake_pulse,
    output logic [1:0]           sleep_state
);
    pstate_t         st;
    pstate_t         target;
    logic            ccl_async;
    logic [NSRC-1:0] allow_cur;
    logic [NSRC-1:0] allow_req;
    logic            pending;
    logic            wake;
    logic            enter;

    // Configurable-logic path is asynchronous with no filter and no edge detect
    always_comb ccl_async = (ccl_filt == '0) && !ccl_edge;

    // Map the mode code onto the sleeping state it requests
    always_comb begin
        case (sleep_mode)
            2'b00:   target = ST_IDLE;
            2'b01:   target = ST_STBY;
            2'b10:   target = ST_PDN;
            default: target = ST_ACT;
        endcase
    end

    slp_wake_mask u_mask_cur (
        .st        (st),
        .rsb       (run_stby),
        .ccl_async (ccl_async),
        .allow     (allow_cur)
    );

    slp_wake_mask u_mask_req (
        .st        (target),
        .rsb       (run_stby),
        .ccl_async (ccl_async),
        .allow     (allow_req)
    );

    // Wake and entry qualification
    always_comb begin
        pending = |(irq & allow_req);
        wake    = (st != ST_ACT) && |(irq & allow_cur);
        enter   = (st == ST_ACT) && sleep_pulse && sleep_en
                  && (sleep_mode != MODE_RSVD) && !pending;
    end

    slp_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enter  (enter),
        .target (target),
        .wake   (wake),
        .st     (st)
    );

    slp_clk_dec u_clk (
        .st     (st),
        .rsb    (run_stby),
        .wake   (wake),
        .clk_en (clk_en)
    );

    // Output drive
    always_comb begin
        wake_pulse  = wake;
        sleep_state = st;
    end
endmodule

// File: rtl/slp_checker.sv
// Property checker for sleep_power_ctrl, attached by bind.
module slp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sleep_en,
    input logic [1:0]  sleep_mode,
    input logic        sleep_pulse,
    input logic [10:0] irq,
    input logic [6:0]  clk_en,
    input logic        wake_pulse,
    input logic [1:0]  sleep_state
);
    p_active_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_state == 2'b00 |-> (!wake_pulse && (&clk_en)));

    p_reserved_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_state == 2'b00 && sleep_pulse && sleep_mode == 2'b11) |=> sleep_state == 2'b00);

    p_disabled_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_state == 2'b00 && !sleep_en) |=> sleep_state == 2'b00);

    p_cpu_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_state != 2'b00 && !wake_pulse) |-> !clk_en[0]);

    p_pdn_clocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_state == 2'b11 && !wake_pulse) |-> (clk_en == 7'b0011100));

    p_wdt_bod_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en[3] && clk_en[4]);

    p_sof_pdn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_state == 2'b11 && irq == 11'h040) |-> !wake_pulse);

    p_wake_clocks_r14: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (&clk_en));

    p_wake_exit_r14: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> (sleep_state == 2'b00 && !wake_pulse));
endmodule

bind sleep_power_ctrl slp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_en    (sleep_en),
    .sleep_mode  (sleep_mode),
    .sleep_pulse (sleep_pulse),
    .irq         (irq),
    .clk_en      (clk_en),
    .wake_pulse  (wake_pulse),
    .sleep_state (sleep_state)
);

// File: tb/tb_sleep_power_ctrl.sv
module tb_sleep_power_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_en = 1'b0;
    logic [1:0]  sleep_mode = 2'b00;
    logic        sleep_pulse = 1'b0;
    logic [6:0]  run_stby = '0;
    logic [1:0]  ccl_filt = '0;
    logic        ccl_edge = 1'b0;
    logic [10:0] irq = '0;
    logic [6:0]  clk_en;
    logic        wake_pulse;
    logic [1:0]  sleep_state;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_power_ctrl dut (
        .clk (clk), .rst_n (rst_n), .sleep_en (sleep_en), .sleep_mode (sleep_mode),
        .sleep_pulse (sleep_pulse), .run_stby (run_stby), .ccl_filt (ccl_filt),
        .ccl_edge (ccl_edge), .irq (irq), .clk_en (clk_en), .wake_pulse (wake_pulse),
        .sleep_state (sleep_state)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected clock enables; st: 1 idle, 2 standby, 3 power-down
    function automatic logic [6:0] exp_clk(int st, logic [6:0] r);
        case (st)
            1: return 7'b1111110;
            2: return {r[6], r[5], 1'b1, 1'b1, r[2], r[1], 1'b0};
            3: return 7'b0011100;
            default: return 7'b1111111;
        endcase
    endfunction

    // Expected wake permission for source s
    function automatic bit exp_wake(int st, int s, logic [6:0] r, bit async);
        if (s <= 2) return 1'b1;
        if (st == 1) return s != 6;
        if (st == 2) begin
            case (s)
                3: return r[5];
                4, 5: return r[2];
                6: return 1'b1;
                7, 8: return r[1];
                9: return r[6];
                default: return 1'b0;
            endcase
        end
        if (s == 3) return async;
        return s == 5;
    endfunction

    // Enter sleep at code m, then test one source
    task automatic run_case(int m, int s, logic [6:0] r, logic [2:0] cfg);
        bit async;
        bit ew;
        string tag;
        async = (cfg == 3'b000);
        ew = exp_wake(m + 1, s, r, async);
        case (s)
            0, 1, 2: tag = "R8";
            3: tag = "R11";
            4, 5: tag = "R12";
            6: tag = "R9";
            7, 8, 9: tag = "R10";
            default: tag = "R13";
        endcase
        @(negedge clk);
        run_stby = r; ccl_filt = cfg[1:0]; ccl_edge = cfg[2];
        irq = '0; sleep_en = 1'b1; sleep_mode = 2'(m); sleep_pulse = 1'b1;
        @(negedge clk);
        sleep_pulse = 1'b0;
        chk(sleep_state == 2'(m + 1), "R2", 32'(sleep_state), 32'(m + 1));
        chk(clk_en == exp_clk(m + 1, r), (m == 0) ? "R4" : (m == 1) ? "R5" : "R6",
            32'(clk_en), 32'(exp_clk(m + 1, r)));
        irq = 11'(1) << s;
        #1;
        chk(wake_pulse == ew, tag, 32'(wake_pulse), 32'(ew));
        chk(clk_en == (ew ? 7'h7f : exp_clk(m + 1, r)), ew ? "R14" : "R7",
            32'(clk_en), 32'(ew ? 7'h7f : exp_clk(m + 1, r)));
        @(negedge clk);
        if (ew) begin
            chk(sleep_state == 2'b00 && !wake_pulse, "R14",
                32'({sleep_state, wake_pulse}), 32'(0));
            irq = '0;
        end else begin
            chk(sleep_state == 2'(m + 1), tag, 32'(sleep_state), 32'(m + 1));
            irq = 11'h001;
            @(negedge clk);
            irq = '0;
            chk(sleep_state == 2'b00, "R8", 32'(sleep_state), 32'(0));
        end
    endtask

    // Try entry that must be refused
    task automatic try_refused(bit en, logic [1:0] m, logic [10:0] rq, string req);
        @(negedge clk);
        irq = rq; sleep_en = en; sleep_mode = m; sleep_pulse = 1'b1;
        @(negedge clk);
        sleep_pulse = 1'b0; irq = '0;
        chk(sleep_state == 2'b00 && clk_en == 7'h7f, req,
            32'({sleep_state, clk_en}), 32'(7'h7f));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sleep_state == 2'b00 && clk_en == 7'h7f && !wake_pulse, "R1",
            32'({sleep_state, clk_en, wake_pulse}), 32'({7'h7f, 1'b0}));
        rst_n = 1'b1;
        @(negedge clk);
        chk(sleep_state == 2'b00 && clk_en == 7'h7f && !wake_pulse, "R1",
            32'({sleep_state, clk_en, wake_pulse}), 32'({7'h7f, 1'b0}));

        try_refused(1'b0, 2'b00, '0, "R2");
        try_refused(1'b1, 2'b11, '0, "R2");
        try_refused(1'b1, 2'b10, 11'h001, "R3");
        try_refused(1'b1, 2'b00, 11'h400, "R3");
        run_stby = 7'b0000100;
        try_refused(1'b1, 2'b01, 11'h010, "R3");

        // Request not acceptable in Power-Down must not block entry
        @(negedge clk);
        irq = 11'h400; sleep_en = 1'b1; sleep_mode = 2'b10; sleep_pulse = 1'b1;
        @(negedge clk);
        sleep_pulse = 1'b0;
        chk(sleep_state == 2'b11 && !wake_pulse, "R3",
            32'({sleep_state, wake_pulse}), 32'(6));
        irq = 11'h001;
        @(negedge clk);
        irq = '0;
        chk(sleep_state == 2'b00, "R14", 32'(sleep_state), 32'(0));

        for (int m = 0; m < 3; m++) begin
            for (int rv = 0; rv < 16; rv++) begin
                logic [6:0] r;
                r = {rv[3], rv[2], rv[0], rv[1], rv[1], rv[0], rv[2]};
                for (int s = 0; s < 11; s++) begin
                    for (int c = 0; c < ((s == 3) ? 8 : 1); c++) begin
                        run_case(m, s, r, 3'(c));
                    end
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule